// File: doc/BRIEF.md
# UART Interrupt Scheduling Controller

This block drives the single interrupt line of a simple serial port and answers the interrupt-identification query. Two event sources exist: receive (RX) and transmit (TX). Each source has its own pending status bit and its own countdown timer. An interrupt caused by host traffic is not posted at once. It is posted only after a settling delay, so that a slow host servicing the port is not flooded. New incoming data is the exception and is posted at once. A TX-enable write is also posted at once when the last TX interrupt is already older than the delay.

The host side of the port presents one strobe per access: a receive-buffer read, a transmit-holding write, an enable write and an identification read. On an enable write, the `rx_ie`/`tx_ie` inputs carry the newly written enable bits. The data path presents `rx_avail` (data still waiting) and a one-cycle `rx_arrive` strobe when a new character lands. The delay in cycles is derived from two parameters: the clock period and the delay time, rounded up. With the default values this is 12 cycles at 50 MHz.

Top module: `uart_irq_sched`

## Requirements
- R1: After reset, `irq` is 0, `iid` is 4'h1, both timers are idle and both status bits are clear. The TX age counts as already older than the delay.
- R2: A timer armed at a clock edge expires exactly DELAY_CYCLES edges later. At that edge it sets its status bit and raises `irq`, but only if its enable input is 1 in that cycle. Otherwise it posts nothing.
- R3: Arming a timer that is already running restarts it from the full DELAY_CYCLES.
- R4: A receive-buffer read clears RX status and drops `irq`. If `rx_avail` and `rx_ie` are both 1 in that cycle, the RX timer is re-armed.
- R5: A transmit-holding write clears TX status and drops `irq`. If `tx_ie` is 1, the TX timer is armed.
- R6: `iid` is 4'h4 when RX status is set, otherwise 4'h2 when TX status is set, otherwise 4'h1. An identification read that reports 4'h2 clears TX status and does not change `irq`.
- R7: An enable write with `tx_ie`=1 posts TX at that edge if more than DELAY_CYCLES edges separate it from the edge of the last TX post. Otherwise it arms the TX timer.
- R8: An enable write with `tx_ie`=0 cancels the TX timer and clears TX status. It drops `irq` only if TX status was set. The TX part of the write is handled before the RX part.
- R9: An enable write with `rx_ie`=1 and `rx_avail`=1 arms the RX timer. Any other enable write cancels the RX timer and clears RX status, dropping `irq` only if RX status was set.
- R10: `rx_arrive` with `rx_ie`=1 sets RX status and raises `irq` at the same edge.
- R11: `irq` is a level that only a receive-buffer read, a transmit-holding write or an enable write can lower. In one cycle the host action is applied first and posts from timers or arrival after it. A timer that the host action arms or cancels does not expire in that cycle.
- R12: At most one of the four host strobes is active in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_ie | input | 1 | RX interrupt enable (new value on an enable write) |
| tx_ie | input | 1 | TX interrupt enable (new value on an enable write) |
| rx_avail | input | 1 | Receive data still waiting |
| rx_arrive | input | 1 | One-cycle strobe: a new character arrived |
| rbr_rd | input | 1 | Host read of the receive buffer |
| thr_wr | input | 1 | Host write of the transmit holding register |
| ier_wr | input | 1 | Host write of the enable register |
| iir_rd | input | 1 | Host read of the identification register |
| irq | output | 1 | Interrupt line, level |
| iid | output | 4 | Identification code for the current status |

## Verification
The properties check every cycle that:
- at most one host strobe is active;
- `irq` never rises without a post source in the previous cycle;
- `irq` stays high in cycles with no lowering access;
- each clearing access (buffer read, holding write, enable write, identification read reporting TX) removes its code from `iid` on the next cycle unless a post of the same source competes;
- new data with RX enabled shows at once.

Exact delay lengths, timer restarts, cancellation, and the TX age window that separates an immediate post from an armed one depend on cycle counts. Only the bench's scenarios, compared cycle by cycle against its own model, can show these.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   typedef logic [3:0] iid_t;

   localparam iid_t IID_NONE = 4'h1;
   localparam iid_t IID_TX   = 4'h2;
   localparam iid_t IID_RX   = 4'h4;

   localparam int unsigned NCH   = 2;
   localparam int unsigned CH_RX = 0;
   localparam int unsigned CH_TX = 1;

   typedef enum logic [1:0] {
      TMR_HOLD   = 2'd0,
      TMR_ARM    = 2'd1,
      TMR_CANCEL = 2'd2
   } tmr_cmd_e;

   function automatic int unsigned delay_to_cycles(input int unsigned dly_ps,
                                                   input int unsigned per_ps);
      return (dly_ps + per_ps - 1) / per_ps;
   endfunction

endpackage

// File: rtl/irq_delay_timer.sv
module irq_delay_timer
   import uart_irq_pkg::*;
#(
   parameter int unsigned DELAY_CYCLES = 12
) (
   input  logic     clk,
   input  logic     rst_n,
   input  tmr_cmd_e cmd,
   output logic     fire
);
   localparam int unsigned CW = $clog2(DELAY_CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(DELAY_CYCLES);
   localparam logic [CW-1:0] ONE  = CW'(1);

   if (DELAY_CYCLES < 2) begin : g_bad_delay
      $error("irq_delay_timer: DELAY_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign fire = (cnt_q == ONE) && (cmd == TMR_HOLD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case (cmd)
            TMR_ARM:    cnt_q <= LOAD;
            TMR_CANCEL: cnt_q <= '0;
            default:    if (cnt_q != '0) cnt_q <= cnt_q - ONE;
         endcase
      end
   end
endmodule

// File: rtl/irq_tx_age.sv
module irq_tx_age #(
   parameter int unsigned LIMIT = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic aged
);
   localparam int unsigned AW = $clog2(LIMIT + 1);
   localparam logic [AW-1:0] SAT = AW'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("irq_tx_age: LIMIT must be at least 1");
   end

   logic [AW-1:0] age_q;

   assign aged = (age_q == SAT);

   always_ff @(posedge clk) begin
      if (!rst_n)            age_q <= SAT;
      else if (clr)          age_q <= '0;
      else if (age_q != SAT) age_q <= age_q + AW'(1);
   end
endmodule

// File: rtl/irq_id_encode.sv
module irq_id_encode
   import uart_irq_pkg::*;
(
   input  logic rx_pend,
   input  logic tx_pend,
   output iid_t iid
);
   always_comb begin
      if (rx_pend)      iid = IID_RX;
      else if (tx_pend) iid = IID_TX;
      else              iid = IID_NONE;
   end
endmodule

// File: rtl/uart_irq_sched.sv
module uart_irq_sched
   import uart_irq_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_PS = 20000,
   parameter int unsigned DELAY_PS      = 225000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_ie,
   input  logic       tx_ie,
   input  logic       rx_avail,
   input  logic       rx_arrive,
   input  logic       rbr_rd,
   input  logic       thr_wr,
   input  logic       ier_wr,
   input  logic       iir_rd,
   output logic       irq,
   output logic [3:0] iid
);
   localparam int unsigned DELAY_CYCLES = delay_to_cycles(DELAY_PS, CLK_PERIOD_PS);

   if (CLK_PERIOD_PS == 0) begin : g_bad_period
      $error("uart_irq_sched: CLK_PERIOD_PS must be non-zero");
   end
   if (DELAY_CYCLES < 2) begin : g_bad_ratio
      $error("uart_irq_sched: delay must span at least two clocks");
   end

   tmr_cmd_e           cmd [NCH];
   logic [NCH-1:0]     tmr_fire;
   logic [NCH-1:0]     st_q, st_h, st_d;
   logic               irq_q, irq_h, irq_d;
   logic               tx_now, tx_post, tx_aged;

   // per-source delay timers
   for (genvar c = 0; c < NCH; c++) begin : g_tmr
      irq_delay_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_tmr (
         .clk   (clk),
         .rst_n (rst_n),
         .cmd   (cmd[c]),
         .fire  (tmr_fire[c])
      );
   end

   irq_tx_age #(.LIMIT(DELAY_CYCLES)) u_age (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tx_post),
      .aged  (tx_aged)
   );

   // host access stage: applied before any post in the same cycle
   always_comb begin
      st_h   = st_q;
      irq_h  = irq_q;
      tx_now = 1'b0;
      for (int c = 0; c < NCH; c++) cmd[c] = TMR_HOLD;

      if (rbr_rd) begin
         st_h[CH_RX] = 1'b0;
         irq_h       = 1'b0;
         if (rx_avail && rx_ie) cmd[CH_RX] = TMR_ARM;
      end else if (thr_wr) begin
         st_h[CH_TX] = 1'b0;
         irq_h       = 1'b0;
         if (tx_ie) cmd[CH_TX] = TMR_ARM;
      end else if (iir_rd) begin
         if (!st_q[CH_RX] && st_q[CH_TX]) st_h[CH_TX] = 1'b0;
      end else if (ier_wr) begin
         // transmit half first
         if (tx_ie) begin
            if (tx_aged) begin
               st_h[CH_TX] = 1'b1;
               irq_h       = 1'b1;
               tx_now      = 1'b1;
            end else begin
               cmd[CH_TX] = TMR_ARM;
            end
         end else begin
            cmd[CH_TX] = TMR_CANCEL;
            if (st_q[CH_TX]) irq_h = 1'b0;
            st_h[CH_TX] = 1'b0;
         end
         // receive half second
         if (rx_ie && rx_avail) begin
            cmd[CH_RX] = TMR_ARM;
         end else begin
            cmd[CH_RX] = TMR_CANCEL;
            if (st_h[CH_RX]) irq_h = 1'b0;
            st_h[CH_RX] = 1'b0;
         end
      end
   end

   // post stage: timer expiries and fresh receive data
   always_comb begin
      st_d    = st_h;
      irq_d   = irq_h;
      tx_post = tx_now;
      if ((tmr_fire[CH_RX] || rx_arrive) && rx_ie) begin
         st_d[CH_RX] = 1'b1;
         irq_d       = 1'b1;
      end
      if (tmr_fire[CH_TX] && tx_ie) begin
         st_d[CH_TX] = 1'b1;
         irq_d       = 1'b1;
         tx_post     = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= '0;
         irq_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         irq_q <= irq_d;
      end
   end

   irq_id_encode u_enc (
      .rx_pend (st_q[CH_RX]),
      .tx_pend (st_q[CH_TX]),
      .iid     (iid)
   );

   assign irq = irq_q;

endmodule

// File: rtl/uart_irq_sched_chk.sv
module uart_irq_sched_chk
   import uart_irq_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       rx_ie,
   input logic       tx_ie,
   input logic       rx_avail,
   input logic       rx_arrive,
   input logic       rbr_rd,
   input logic       thr_wr,
   input logic       ier_wr,
   input logic       iir_rd,
   input logic       irq,
   input logic [3:0] iid,
   input logic       rx_fire,
   input logic       tx_fire
);
   a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rbr_rd, thr_wr, ier_wr, iir_rd}));

   a_r10_arrive_now: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_arrive && rx_ie) |=> (irq && iid == IID_RX));

   a_r4_rbr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rbr_rd && !(rx_arrive && rx_ie) && !rx_fire) |=> (iid != IID_RX));

   a_r5_thr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> (iid != IID_TX));

   a_r6_iir_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd && iid == IID_TX && !tx_fire) |=> (iid != IID_TX));

   a_r8_tx_off: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_wr && !tx_ie) |=> (iid != IID_TX));

   a_r9_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_wr && !(rx_ie && rx_avail) && !(rx_arrive && rx_ie)) |=> (iid != IID_RX));

   a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(rx_arrive || rx_fire || tx_fire || ier_wr));

   a_r11_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !rbr_rd && !thr_wr && !ier_wr) |=> irq);
endmodule

bind uart_irq_sched uart_irq_sched_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_ie     (rx_ie),
   .tx_ie     (tx_ie),
   .rx_avail  (rx_avail),
   .rx_arrive (rx_arrive),
   .rbr_rd    (rbr_rd),
   .thr_wr    (thr_wr),
   .ier_wr    (ier_wr),
   .iir_rd    (iir_rd),
   .irq       (irq),
   .iid       (iid),
   .rx_fire   (tmr_fire[0]),
   .tx_fire   (tmr_fire[1])
);

// File: tb/uart_irq_sched_test.sv
module uart_irq_sched_test;
   localparam int D = 12;  // 225 ns at a 20 ns clock, rounded up

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_ie = 0, tx_ie = 0, rx_avail = 0, rx_arrive = 0;
   logic rbr_rd = 0, thr_wr = 0, ier_wr = 0, iir_rd = 0;
   logic irq;
   logic [3:0] iid;

   int n_tests = 0;
   int n_fail  = 0;
   bit done = 0;

   // bench model state
   bit m_irq, m_rx, m_tx;
   int m_rxt, m_txt, m_age;

   always #10 clk = ~clk;

   uart_irq_sched uut (
      .clk(clk), .rst_n(rst_n), .rx_ie(rx_ie), .tx_ie(tx_ie),
      .rx_avail(rx_avail), .rx_arrive(rx_arrive), .rbr_rd(rbr_rd),
      .thr_wr(thr_wr), .ier_wr(ier_wr), .iir_rd(iir_rd),
      .irq(irq), .iid(iid)
   );

   function automatic logic [3:0] exp_iid(bit rx, bit tx);
      if (rx) return 4'h4;
      if (tx) return 4'h2;
      return 4'h1;
   endfunction

   task automatic model_reset();
      m_irq = 0; m_rx = 0; m_tx = 0; m_rxt = 0; m_txt = 0; m_age = D;
   endtask

   // next state from the requirements, evaluated with the current inputs
   task automatic model_edge();
      bit rxa = 0, rxc = 0, txa = 0, txc = 0, posted = 0;
      bit n_irq = m_irq, n_rx = m_rx, n_tx = m_tx;
      bit rf, tf;
      if (rbr_rd) begin
         n_rx = 0; n_irq = 0; rxa = rx_avail && rx_ie;
      end else if (thr_wr) begin
         n_tx = 0; n_irq = 0; txa = tx_ie;
      end else if (iir_rd) begin
         if (!m_rx && m_tx) n_tx = 0;
      end else if (ier_wr) begin
         if (tx_ie) begin
            if (m_age >= D) begin n_tx = 1; n_irq = 1; posted = 1; end
            else txa = 1;
         end else begin
            txc = 1; if (m_tx) n_irq = 0; n_tx = 0;
         end
         if (rx_ie && rx_avail) rxa = 1;
         else begin rxc = 1; if (n_rx) n_irq = 0; n_rx = 0; end
      end
      rf = (m_rxt == 1) && !rxa && !rxc;
      tf = (m_txt == 1) && !txa && !txc;
      if ((rf || rx_arrive) && rx_ie) begin n_rx = 1; n_irq = 1; end
      if (tf && tx_ie) begin n_tx = 1; n_irq = 1; posted = 1; end
      m_rxt = rxa ? D : rxc ? 0 : (m_rxt > 0 ? m_rxt - 1 : 0);
      m_txt = txa ? D : txc ? 0 : (m_txt > 0 ? m_txt - 1 : 0);
      m_age = posted ? 0 : (m_age < D ? m_age + 1 : D);
      m_irq = n_irq; m_rx = n_rx; m_tx = n_tx;
   endtask

   task automatic check(string tag);
      logic [3:0] e = exp_iid(m_rx, m_tx);
      n_tests++;
      if (irq !== m_irq || iid !== e) begin
         n_fail++;
         $display("FAIL %s: irq=%0b iid=%h expected irq=%0b iid=%h",
                  tag, irq, iid, m_irq, e);
      end
   endtask

   // one clock: inputs already set after a falling edge
   task automatic step(string tag);
      model_edge();
      @(posedge clk);
      @(negedge clk);
      rx_arrive = 0; rbr_rd = 0; thr_wr = 0; ier_wr = 0; iir_rd = 0;
      check(tag);
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      model_reset();
      repeat (3) @(negedge clk);
      check("R1 reset");
      rst_n = 1;

      // R10: arrival posts at once
      rx_ie = 1; rx_arrive = 1; step("R10 arrival");
      iir_rd = 1; step("R6 RX priority read");
      // R4: buffer read with data remaining re-arms
      rbr_rd = 1; rx_avail = 1; step("R4 buffer read");
      idle(D - 1, "R2 RX wait");
      idle(1, "R2 RX expiry");
      rx_avail = 0; rbr_rd = 1; step("R4 last read");
      // R7: aged enable write fires immediately
      tx_ie = 1; ier_wr = 1; step("R7 immediate");
      iir_rd = 1; step("R6 TX read clears");
      idle(2, "R11 level held");
      // R7: young enable write arms timer
      ier_wr = 1; step("R7 armed");
      idle(D - 1, "R2 TX wait");
      idle(1, "R2 TX expiry");
      // R5 / R3: holding writes restart
      thr_wr = 1; step("R5 holding write");
      idle(5, "R3 wait");
      thr_wr = 1; step("R3 restart");
      idle(D, "R3 full interval");
      // R8: cancel while running
      thr_wr = 1; step("R5 arm again");
      idle(3, "R8 pre");
      tx_ie = 0; ier_wr = 1; step("R8 disable");
      idle(D + 2, "R8 cancelled");
      // R2: enable clear at expiry blocks post
      tx_ie = 1; thr_wr = 1; step("R5 arm");
      tx_ie = 0; idle(D + 2, "R2 disabled at expiry");
      // R9: enable write without data cancels RX
      rx_ie = 1; rx_arrive = 1; step("R10 arrival2");
      rx_avail = 0; ier_wr = 1; step("R9 cancel RX");
      rx_avail = 1; ier_wr = 1; step("R9 arm RX");
      idle(D + 1, "R9 RX expiry");

      // constrained random traffic
      for (int k = 0; k < 4000; k++) begin
         int r = $urandom % 16;
         case (r)
            0: rbr_rd = 1;
            1: thr_wr = 1;
            2: begin ier_wr = 1; rx_ie = $urandom % 2; tx_ie = $urandom % 3 != 0; end
            3: iir_rd = 1;
            default: ;
         endcase
         if ($urandom % 12 == 0) rx_arrive = 1;
         if ($urandom % 8 == 0) rx_avail = ~rx_avail;
         step("R11 random R12");
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule